// File: doc/BRIEF.md
# Read-Based Deferrable Row Refresh Engine

This block keeps the rows of a DRAM alive without ever using the device's own refresh command. The banks are split into private resources. Each resource has one owner, and this block serves each resource on its own. For every resource it counts a refresh interval in units of a shared timebase tick. Each time the interval expires, it adds one refresh read to a pending count. It names the next bank and row that the scheduler must activate and read to recharge that row.

A refresh is never placed inside a client transaction. While the resource's busy input is high, the request is held back and the pending reads pile up. When busy drops, the request is raised, and each grant from the scheduler uses up one pending read and moves the target address on. The interval is derived from the retention time minus a safety margin, spread over all reads a resource owes per retention period. Because of this, a refresh that has been deferred within the allowed depth still meets the deadline. If the pending count reaches the deferral limit, a sticky overdue flag reports the violation.

Top module: `rowread_refresh`

## Requirements
- R1: After reset every resource has request low, overdue low, and its target address at bank 0, row 0.
- R2: For a resource, an expiry occurs on every REFI-th tick pulse after reset, counting only cycles where tick_i is high. Each expiry adds one pending read, which takes effect at the clock edge of that tick.
- R3: req_o of a resource is high exactly while its pending count is nonzero and its busy_i bit is low. While busy_i is high, pending reads are deferred and the request stays low.
- R4: A grant is accepted only in a cycle where the resource's req_o and grant_i are both high. Each accepted grant removes one pending read at that edge. A grant without a request changes neither the pending count nor the address.
- R5: Each accepted grant advances the target address. The bank index (flat field BANK_W bits wide per resource, resource 0 in the low bits) increments first. After the last bank it returns to 0 and the row (ROW_W bits per resource, same packing) increments. After the last row, the row wraps to 0.
- R6: The pending count saturates at MAX_DEFER. In the cycle after the count is seen at MAX_DEFER, overdue_o of that resource goes high, and it stays high until reset.
- R7: The resources are independent. Busy, grant and tick history on one resource never changes the request, address or overdue flag of another.
- R8: REFI = (RETENTION_TICKS − MARGIN_TICKS) / (ROWS × BANKS_PER_RES), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse that advances all interval timers |
| busy_i | input | NUM_RES | Resource is inside a client transaction |
| grant_i | input | NUM_RES | Scheduler grants a refresh read slot |
| req_o | output | NUM_RES | Refresh read requested |
| bank_o | output | NUM_RES*BANK_W | Bank to read, per resource |
| row_o | output | NUM_RES*ROW_W | Row to read, per resource |
| overdue_o | output | NUM_RES | Deferral limit reached (sticky) |

## Verification
The request is combinational from busy_i and the registered pending count. The bench therefore compares it shortly after driving inputs in the same cycle. The address, pending count and overdue flag are registered, and each changes at the first rising edge after its cause. The overdue flag is one edge later still, because it looks at the count once that count has saturated. The reference model in the bench updates its state at each rising edge. All outputs are compared just after the next falling-edge drive, so every result is checked in the cycle it is due.

// File: rtl/rr_pkg.sv
package rr_pkg;
  function automatic int unsigned safe_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int unsigned calc_refi(input int unsigned ret, input int unsigned margin,
                                            input int unsigned reads);
    int unsigned q;
    q = (ret > margin) ? (ret - margin) / reads : 0;
    return (q == 0) ? 1 : q;
  endfunction
endpackage

// File: rtl/rr_interval_timer.sv
module rr_interval_timer #(
  parameter int unsigned REFI = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = rr_pkg::safe_w(REFI);
  localparam logic [CW-1:0] RELOAD = CW'(REFI - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RELOAD;
    end else if (tick_i) begin
      if (cnt_q == '0) cnt_q <= RELOAD;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rr_pending_ctr.sv
module rr_pending_ctr #(
  parameter int unsigned MAX_DEFER = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic nonzero_o,
  output logic overdue_o
);
  localparam int unsigned PW = rr_pkg::safe_w(MAX_DEFER + 1);
  localparam logic [PW:0] LIMIT = (PW+1)'(MAX_DEFER);

  logic [PW-1:0] pend_q;
  logic [PW:0]   sum;
  logic          ovd_q;

  always_comb begin
    sum = {1'b0, pend_q} + {{PW{1'b0}}, inc_i};
    if (dec_i && (pend_q != '0)) sum = sum - 1'b1;
    if (sum > LIMIT) sum = LIMIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ovd_q  <= 1'b0;
    end else begin
      pend_q <= sum[PW-1:0];
      if ({1'b0, pend_q} == LIMIT) ovd_q <= 1'b1;
    end
  end

  assign nonzero_o = (pend_q != '0);
  assign overdue_o = ovd_q;
endmodule

// File: rtl/rr_addr_seq.sv
module rr_addr_seq #(
  parameter int unsigned BANKS = 2,
  parameter int unsigned ROWS  = 8192,
  parameter int unsigned BW    = 1,
  parameter int unsigned RW    = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [BW-1:0] bank_o,
  output logic [RW-1:0] row_o
);
  localparam logic [BW-1:0] LAST_BANK = BW'(BANKS - 1);
  localparam logic [RW-1:0] LAST_ROW  = RW'(ROWS - 1);

  logic [BW-1:0] bank_q;
  logic [RW-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      row_q  <= '0;
    end else if (adv_i) begin
      if (bank_q == LAST_BANK) begin
        bank_q <= '0;
        row_q  <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
      end else begin
        bank_q <= bank_q + 1'b1;
      end
    end
  end

  assign bank_o = bank_q;
  assign row_o  = row_q;
endmodule

// File: rtl/rr_resource.sv
module rr_resource #(
  parameter int unsigned REFI      = 4,
  parameter int unsigned MAX_DEFER = 8,
  parameter int unsigned BANKS     = 2,
  parameter int unsigned ROWS      = 8192,
  parameter int unsigned BW        = 1,
  parameter int unsigned RW        = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          busy_i,
  input  logic          grant_i,
  output logic          req_o,
  output logic [BW-1:0] bank_o,
  output logic [RW-1:0] row_o,
  output logic          overdue_o
);
  logic expire, nonzero, accept;

  rr_interval_timer #(.REFI(REFI)) u_timer (
    .clk_i, .rst_ni, .tick_i, .expire_o(expire)
  );

  // deferral: no request while the owner's transaction is running
  assign req_o  = nonzero && !busy_i;
  assign accept = req_o && grant_i;

  rr_pending_ctr #(.MAX_DEFER(MAX_DEFER)) u_pend (
    .clk_i, .rst_ni, .inc_i(expire), .dec_i(accept),
    .nonzero_o(nonzero), .overdue_o
  );

  rr_addr_seq #(.BANKS(BANKS), .ROWS(ROWS), .BW(BW), .RW(RW)) u_addr (
    .clk_i, .rst_ni, .adv_i(accept), .bank_o, .row_o
  );
endmodule

// File: rtl/rowread_refresh.sv
module rowread_refresh #(
  parameter int unsigned NUM_RES         = 4,
  parameter int unsigned BANKS_PER_RES   = 2,
  parameter int unsigned ROWS            = 8192,
  parameter int unsigned RETENTION_TICKS = 64000,
  parameter int unsigned MARGIN_TICKS    = 4000,
  parameter int unsigned MAX_DEFER       = 8,
  localparam int unsigned BANK_W = rr_pkg::safe_w(BANKS_PER_RES),
  localparam int unsigned ROW_W  = rr_pkg::safe_w(ROWS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tick_i,
  input  logic [NUM_RES-1:0]          busy_i,
  input  logic [NUM_RES-1:0]          grant_i,
  output logic [NUM_RES-1:0]          req_o,
  output logic [NUM_RES*BANK_W-1:0]   bank_o,
  output logic [NUM_RES*ROW_W-1:0]    row_o,
  output logic [NUM_RES-1:0]          overdue_o
);
  localparam int unsigned REFI =
    rr_pkg::calc_refi(RETENTION_TICKS, MARGIN_TICKS, ROWS * BANKS_PER_RES);

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    rr_resource #(
      .REFI(REFI), .MAX_DEFER(MAX_DEFER), .BANKS(BANKS_PER_RES),
      .ROWS(ROWS), .BW(BANK_W), .RW(ROW_W)
    ) u_res (
      .clk_i,
      .rst_ni,
      .tick_i,
      .busy_i   (busy_i[g]),
      .grant_i  (grant_i[g]),
      .req_o    (req_o[g]),
      .bank_o   (bank_o[g*BANK_W +: BANK_W]),
      .row_o    (row_o[g*ROW_W +: ROW_W]),
      .overdue_o(overdue_o[g])
    );
  end
endmodule

// File: rtl/rowread_refresh_chk.sv
module rowread_refresh_chk #(
  parameter int unsigned NUM_RES = 4,
  parameter int unsigned BANKS   = 2,
  parameter int unsigned BW      = 1,
  parameter int unsigned RW      = 13
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_RES-1:0]     busy_i,
  input logic [NUM_RES-1:0]     grant_i,
  input logic [NUM_RES-1:0]     req_o,
  input logic [NUM_RES*BW-1:0]  bank_o,
  input logic [NUM_RES*RW-1:0]  row_o,
  input logic [NUM_RES-1:0]     overdue_o
);
  for (genvar g = 0; g < NUM_RES; g++) begin : g_chk
    p_req_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o[g] |-> !busy_i[g]);

    p_overdue_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overdue_o[g] |=> overdue_o[g]);

    p_addr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_o[g] && grant_i[g]) |=> ($stable(bank_o[g*BW +: BW]) && $stable(row_o[g*RW +: RW])));

    p_bank_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o[g] && grant_i[g] && (bank_o[g*BW +: BW] != BW'(BANKS - 1)))
      |=> ((bank_o[g*BW +: BW] == $past(bank_o[g*BW +: BW]) + 1'b1)
           && $stable(row_o[g*RW +: RW])));
  end
endmodule

bind rowread_refresh rowread_refresh_chk #(
  .NUM_RES(NUM_RES), .BANKS(BANKS_PER_RES), .BW(BANK_W), .RW(ROW_W)
) u_chk (
  .clk_i, .rst_ni, .busy_i, .grant_i, .req_o, .bank_o, .row_o, .overdue_o
);

// File: tb/rowread_refresh_tb_top.sv
`timescale 1ns/1ps
module rowread_refresh_tb_top;
  localparam int NR = 2, NB = 2, NROW = 4, RET = 40, MARG = 8, MAXD = 3;
  localparam int REFI = (RET - MARG) / (NROW * NB); // R8: 4 ticks
  localparam int BW = 1, RW = 2;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [NR-1:0] busy = '0, grant = '0, req, ovd;
  logic [NR*BW-1:0] bank;
  logic [NR*RW-1:0] row;

  always #4 clk = ~clk; // 125 MHz

  rowread_refresh #(.NUM_RES(NR), .BANKS_PER_RES(NB), .ROWS(NROW),
    .RETENTION_TICKS(RET), .MARGIN_TICKS(MARG), .MAX_DEFER(MAXD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .busy_i(busy), .grant_i(grant),
    .req_o(req), .bank_o(bank), .row_o(row), .overdue_o(ovd));

  int errors = 0, checks = 0;
  int m_t[NR], m_p[NR], m_b[NR], m_r[NR], m_o[NR];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(bit t, logic [NR-1:0] b, logic [NR-1:0] g);
    @(negedge clk);
    tick = t; busy = b; grant = g;
  endtask

  // compare with model, then advance one edge
  task automatic cyc();
    #1;
    for (int i = 0; i < NR; i++) begin
      int mreq;
      mreq = (m_p[i] > 0 && !busy[i]) ? 1 : 0;
      chk("R3 R7 req", int'(req[i]), mreq);
      chk("R5 bank", int'(bank[i*BW +: BW]), m_b[i]);
      chk("R5 row", int'(row[i*RW +: RW]), m_r[i]);
      chk("R6 overdue", int'(ovd[i]), m_o[i]);
    end
    @(posedge clk);
    for (int i = 0; i < NR; i++) begin
      int acc, ex;
      acc = (m_p[i] > 0 && !busy[i] && grant[i]) ? 1 : 0;
      ex  = (tick && m_t[i] == 0) ? 1 : 0;
      if (tick) m_t[i] = (m_t[i] == 0) ? REFI - 1 : m_t[i] - 1;
      if (m_p[i] == MAXD) m_o[i] = 1;
      m_p[i] = m_p[i] + ex - acc;
      if (m_p[i] > MAXD) m_p[i] = MAXD;
      if (acc) begin
        if (m_b[i] == NB - 1) begin
          m_b[i] = 0;
          m_r[i] = (m_r[i] == NROW - 1) ? 0 : m_r[i] + 1;
        end else m_b[i]++;
      end
    end
  endtask

  task automatic run(int n, bit t, logic [NR-1:0] b, logic [NR-1:0] g);
    for (int k = 0; k < n; k++) begin drive(t, b, g); cyc(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin
      m_t[i] = REFI - 1; m_p[i] = 0; m_b[i] = 0; m_r[i] = 0; m_o[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 req", int'(req), 0);
    chk("R1 bank", int'(bank), 0);
    chk("R1 row", int'(row), 0);
    chk("R1 overdue", int'(ovd), 0);

    // R8 / R2: first expiry on the 4th tick
    run(3, 1, 2'b00, 2'b00);
    drive(1, 2'b00, 2'b00); #1 chk("R8 no req before REFI ticks", int'(req), 0); cyc();
    drive(0, 2'b00, 2'b00); #1 chk("R2 req after expiry", int'(req), 3); cyc();
    run(1, 0, 2'b00, 2'b11);

    // R3 deferral while busy
    run(8, 1, 2'b11, 2'b00);
    drive(0, 2'b11, 2'b00); #1 chk("R3 held while busy", int'(req), 0); cyc();
    drive(0, 2'b00, 2'b00); #1 chk("R3 req after busy drops", int'(req), 3); cyc();
    run(2, 0, 2'b00, 2'b01);
    drive(0, 2'b00, 2'b00); #1;
    chk("R4 R7 req after two grants", int'(req), 2);
    chk("R5 bank0", int'(bank[0 +: BW]), 1);
    chk("R5 row0", int'(row[0 +: RW]), 1);
    cyc();
    run(1, 0, 2'b00, 2'b01); // grant without request
    drive(0, 2'b00, 2'b00); #1;
    chk("R4 ignored grant bank0", int'(bank[0 +: BW]), 1);
    chk("R4 ignored grant row0", int'(row[0 +: RW]), 1);
    cyc();
    run(2, 0, 2'b00, 2'b10);

    // R6 saturation and sticky overdue, R7 isolation
    run(14, 1, 2'b01, 2'b10);
    drive(0, 2'b01, 2'b00); #1 chk("R6 R7 overdue", int'(ovd), 1); cyc();
    run(4, 0, 2'b00, 2'b01);
    drive(0, 2'b00, 2'b00); #1;
    chk("R6 saturated at limit", int'(req[0]), 0);
    chk("R6 overdue sticky", int'(ovd), 1);
    chk("R5 bank0 after saturation", int'(bank[0 +: BW]), 0);
    chk("R5 row0 after saturation", int'(row[0 +: RW]), 3);
    cyc();

    // R5 row wrap
    run(6, 1, 2'b11, 2'b00);
    run(2, 0, 2'b00, 2'b11);
    drive(0, 2'b00, 2'b00); #1;
    chk("R5 wrap bank", int'(bank), 0);
    chk("R5 wrap row", int'(row), 0);
    cyc();

    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      drive(bit'($urandom % 2), NR'($urandom), NR'($urandom));
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule